// File: doc/BRIEF.md
# TDM Channel Bit Extractor

This block sits between a framed TDM receive stream and an HDLC receiver. It picks out the bits of a single programmable channel and hands them on one at a time. The frame holds 32 timeslots of 8 bits. Each clock carries one received bit. A frame strobe marks the first bit of every frame, and a parity line, sampled with that strobe, tells whether the frame is odd or even.

Three settings choose the channel together. The first is a pair of enables for even and odd frames. The second is a 5-bit timeslot index. The third is an 8-bit mask with one bit per position in that timeslot, and any pattern of mask bits is allowed. A channel enable gates the whole path. All settings are captured at the frame strobe, so a change made part way through a frame never mixes two selections. Each selected bit comes out registered, one clock after it arrived, with a valid strobe beside it.

Top module: `tdm_slot_tap`

## Requirements
- R1: `odd_frame` is sampled with `frame_start` (1 = odd frame, 0 = even frame). Bits are passed only in frames whose parity is enabled: even frames need `cfg_even`=1 and odd frames need `cfg_odd`=1. With both set, every frame is used.
- R2: Only the timeslot numbered `cfg_slot` (0 to 31) is passed. The bit presented with `frame_start` is frame position 0, and timeslot s covers frame positions 8*s to 8*s+7.
- R3: Bit k of the timeslot, where k=0 is the first bit received, is passed only when `cfg_mask[7-k]` is 1. Any mask pattern is honoured, including patterns whose set bits are not adjacent.
- R4: While the captured `cfg_en` is 0, `out_valid` stays 0.
- R5: When a bit is selected, `out_valid` is 1 in the clock after that bit was presented on `rx_bit`, and `out_bit` then equals that bit.
- R6: If `cfg_even` and `cfg_odd` are both 0, or if `cfg_mask` is all zeros, no valid strobe is produced.
- R7: All `cfg_*` inputs and `odd_frame` are captured at `frame_start`. Changing them within a frame has no effect until the next `frame_start`.
- R8: After reset `out_valid` is 0. No bit is passed until the first `frame_start` has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one received bit per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_bit | input | 1 | Serial receive data |
| frame_start | input | 1 | High with the first bit of each frame |
| odd_frame | input | 1 | Frame parity, sampled with frame_start (1 = odd) |
| cfg_even | input | 1 | Enable extraction from even frames |
| cfg_odd | input | 1 | Enable extraction from odd frames |
| cfg_slot | input | 5 | Timeslot carrying the channel |
| cfg_mask | input | 8 | Per-bit enable, bit 7 = first bit of the timeslot |
| cfg_en | input | 1 | Channel enable |
| out_bit | output | 1 | Extracted data bit |
| out_valid | output | 1 | High for one clock per extracted bit |

## Verification
The case hardest to reach from the ports is a configuration change that lands in the middle of a frame. The design must keep the settings it captured for the rest of that frame and switch only at the next strobe. To reach it, the stimulus rewrites every setting at frame position 100, just before the selected timeslot. It then checks that the whole frame still follows the old selection and that the following frame follows the new one. A second awkward case is the stretch after reset but before the first frame strobe. The bench drives a fully open selection through that stretch and expects silence.

// File: rtl/tdm_slot_tap.sv
module tdm_slot_tap #(
  parameter int SLOTS     = 32,
  parameter int SLOT_BITS = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rx_bit,
  input  logic                         frame_start,
  input  logic                         odd_frame,
  input  logic                         cfg_even,
  input  logic                         cfg_odd,
  input  logic [$clog2(SLOTS)-1:0]     cfg_slot,
  input  logic [SLOT_BITS-1:0]         cfg_mask,
  input  logic                         cfg_en,
  output logic                         out_bit,
  output logic                         out_valid
);
  localparam int SW = $clog2(SLOTS);
  localparam int BW = $clog2(SLOT_BITS);
  localparam int PW = SW + BW;

  logic                 act_even, act_odd, act_en, act_par, synced;
  logic [SW-1:0]        act_slot;
  logic [SLOT_BITS-1:0] act_mask;
  logic [PW-1:0]        pos;

  wire                 eff_even = frame_start ? cfg_even  : act_even;
  wire                 eff_odd  = frame_start ? cfg_odd   : act_odd;
  wire                 eff_en   = frame_start ? cfg_en    : act_en;
  wire                 eff_par  = frame_start ? odd_frame : act_par;
  wire [SW-1:0]        eff_slot = frame_start ? cfg_slot  : act_slot;
  wire [SLOT_BITS-1:0] eff_mask = frame_start ? cfg_mask  : act_mask;
  wire [PW-1:0]        cur_pos  = frame_start ? '0 : pos;

  wire [BW-1:0] bit_idx  = cur_pos[BW-1:0];
  wire [BW-1:0] mask_idx = BW'(SLOT_BITS - 1) - bit_idx;
  wire          par_ok   = eff_par ? eff_odd : eff_even;
  wire          slot_hit = (cur_pos[PW-1:BW] == eff_slot);
  wire          take     = (synced | frame_start) & eff_en & par_ok & slot_hit & eff_mask[mask_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_even  <= 1'b0;
      act_odd   <= 1'b0;
      act_en    <= 1'b0;
      act_par   <= 1'b0;
      act_slot  <= '0;
      act_mask  <= '0;
      synced    <= 1'b0;
      pos       <= '0;
      out_bit   <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      if (frame_start) begin
        act_even <= cfg_even;
        act_odd  <= cfg_odd;
        act_en   <= cfg_en;
        act_par  <= odd_frame;
        act_slot <= cfg_slot;
        act_mask <= cfg_mask;
        synced   <= 1'b1;
      end
      pos       <= cur_pos + 1'b1;
      out_bit   <= rx_bit;
      out_valid <= take;
    end
  end

  // R4: a disabled channel captured at the strobe gives nothing on the strobe bit
  p_en_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !cfg_en) |=> !out_valid);

  // R6: empty mask or no parity enabled
  p_mask_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && cfg_mask == '0) |=> !out_valid);

  p_no_parity_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !cfg_even && !cfg_odd) |=> !out_valid);

  // R7: captured selection only moves at a frame strobe
  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(act_mask) && $stable(act_slot) && $stable(act_en) && $stable(act_par)));

  // R8: nothing before the first strobe
  p_no_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!synced && !frame_start) |=> !out_valid);

  // R2: position restarts at the strobe
  p_pos_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (pos == PW'(1)));
endmodule

// File: tb/tdm_slot_tap_tb.sv
module tdm_slot_tap_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_bit = 1'b0, frame_start = 1'b0, odd_frame = 1'b0;
  logic cfg_even = 1'b0, cfg_odd = 1'b0, cfg_en = 1'b0;
  logic [4:0] cfg_slot = '0;
  logic [7:0] cfg_mask = '0;
  logic out_bit, out_valid;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  tdm_slot_tap dut_i (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .frame_start(frame_start),
    .odd_frame(odd_frame), .cfg_even(cfg_even), .cfg_odd(cfg_odd),
    .cfg_slot(cfg_slot), .cfg_mask(cfg_mask), .cfg_en(cfg_en),
    .out_bit(out_bit), .out_valid(out_valid));

  // {odd_frame, even_en, odd_en, chan_en, slot[4:0], mask[7:0]}
  localparam logic [16:0] VEC [8] = '{
    {1'b0, 1'b1, 1'b0, 1'b1, 5'd3,  8'hFF},  // R2 full timeslot, even frame
    {1'b1, 1'b1, 1'b0, 1'b1, 5'd3,  8'hFF},  // R1 odd frame, only even enabled
    {1'b1, 1'b0, 1'b1, 1'b1, 5'd31, 8'hA5},  // R3 split mask, last slot
    {1'b0, 1'b1, 1'b1, 1'b1, 5'd0,  8'h80},  // R3 first bit of slot 0
    {1'b1, 1'b1, 1'b1, 1'b1, 5'd17, 8'h01},  // R3 last bit only
    {1'b0, 1'b1, 1'b1, 1'b0, 5'd5,  8'hFF},  // R4 channel off
    {1'b0, 1'b0, 1'b0, 1'b1, 5'd5,  8'hFF},  // R6 no parity enabled
    {1'b1, 1'b1, 1'b1, 1'b1, 5'd5,  8'h00}   // R6 empty mask
  };

  task automatic check(input string req, input logic [255:0] got, input logic [255:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic set_cfg(input logic [16:0] c);
    {odd_frame, cfg_even, cfg_odd, cfg_en, cfg_slot, cfg_mask} = c;
  endtask

  // Drive one frame with config c; at bit chg switch to alt. Expected follows c.
  task automatic run_frame(input string req, input logic [16:0] c,
                           input logic [16:0] alt, input int chg);
    logic [255:0] gv, gd, ev, ed;
    logic par, e0, o0, en;
    logic [4:0] sl;
    logic [7:0] mk;
    {par, e0, o0, en, sl, mk} = c;
    gv = '0; gd = '0; ev = '0; ed = '0;
    for (int i = 0; i < 256; i++) begin
      frame_start = (i == 0);
      if (i == 0) set_cfg(c);
      else if (i == chg) set_cfg(alt);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rx_bit = lfsr[0];
      if (en && (par ? o0 : e0) && (i / 8 == int'(sl)) && mk[7 - (i % 8)]) begin
        ev[i] = 1'b1;
        ed[i] = rx_bit;
      end
      @(negedge clk);
      gv[i] = out_valid;
      gd[i] = out_bit & out_valid;
    end
    frame_start = 1'b0;
    check({req, " valid"}, gv, ev);
    check({req, " data R5"}, gd, ed);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R8 reset actual=%b expected=0", out_valid);
    end
    rst_n = 1'b1;
    // R8: open selection but no frame strobe yet
    set_cfg({1'b0, 1'b1, 1'b1, 1'b1, 5'd0, 8'hFF});
    begin
      logic seen;
      seen = 1'b0;
      for (int i = 0; i < 40; i++) begin
        rx_bit = i[0];
        @(negedge clk);
        seen |= out_valid;
      end
      checks++;
      if (seen !== 1'b0) begin
        fails++;
        $display("FAIL R8 presync actual=%b expected=0", seen);
      end
    end
    for (int v = 0; v < 8; v++)
      run_frame("R1/R2/R3/R4/R6 vector", VEC[v], VEC[v], 999);
    // R7: mid-frame change to a different slot/mask/parity, then it applies next frame
    run_frame("R7 midframe", {1'b0, 1'b1, 1'b0, 1'b1, 5'd20, 8'h3C},
              {1'b1, 1'b0, 1'b1, 1'b1, 5'd13, 8'hC3}, 100);
    run_frame("R7 nextframe", {1'b1, 1'b0, 1'b1, 1'b1, 5'd13, 8'hC3},
              {1'b1, 1'b0, 1'b1, 1'b1, 5'd13, 8'hC3}, 999);
    // R7: disabling mid-frame does not cut the current frame short
    run_frame("R7 late disable", {1'b0, 1'b1, 1'b1, 1'b1, 5'd30, 8'hFF},
              {1'b0, 1'b1, 1'b1, 1'b0, 5'd30, 8'hFF}, 200);
    // R1: odd frame with both parities enabled
    run_frame("R1 both parity", {1'b1, 1'b1, 1'b1, 1'b1, 5'd9, 8'h66},
              {1'b1, 1'b1, 1'b1, 1'b1, 5'd9, 8'h66}, 999);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule